// File: doc/BRIEF.md
# Binary32 Iterative Divider with Status Flags

This block divides one IEEE-754 binary32 operand by another over many clock cycles. It also reports floating-point status in the usual RISC style. A one-cycle `start` pulse captures the dividend, the divisor, a rounding mode, a flush-to-zero control, a record request and five exception enables. The block raises `busy` until the quotient is ready. It then pulses `done` for one cycle and holds the result until the next completion.

Special operands are settled without iterating. These are NaNs, infinities and zeros, including denormals that flush mode treats as zero. Each invalid case raises its own cause bit. Finite quotients come from a restoring radix-2 loop that produces 25 quotient bits plus a sticky bit. The quotient is then rounded in one of four modes, with gradual underflow, or with a flush to a signed zero when flush mode is on.

Exception bits are sticky and clear only at reset. A summary bit, an invalid summary and an enabled-exception summary are derived from them. When a record is requested, four of these bits are mirrored into a condition nibble.

Top module: `fp32_div_status`

## Requirements
- R1: A `start` pulse is taken only while `busy` is low. `busy` stays high from the next cycle until the result is ready. `done` is a single-cycle pulse, and `q` changes only in a `done` cycle. A `start` that arrives while `busy` is high is ignored.
- R2: A finite nonzero dividend divided by ±0 gives an infinity whose sign is the XOR of the operand signs. It sets the zero-divide bit `exc[1]`.
- R3: 0/0 gives `32'h7FC00000` and sets the zero-over-zero bit `exc[4]`. The invalid summary `vx` follows.
- R4: ±∞/±∞ gives `32'h7FC00000` and sets the infinity-over-infinity bit `exc[5]`.
- R5: If either operand is a NaN, the dividend's NaN if it has one (otherwise the divisor's) is returned with fraction bit 22 forced to 1. A signalling NaN operand (bit 22 clear) sets `exc[6]`.
- R6: A finite quotient is rounded according to `rmode`: 00 to nearest-even, 01 toward zero, 10 toward +∞, 11 toward −∞. Its sign is the XOR of the operand signs.
- R7: `fi` is 1 when any discarded quotient bit is nonzero, and `fr` is 1 only when rounding raised the magnitude. An inexact result sets the inexact bit `exc[0]`.
- R8: A rounded exponent beyond the binary32 range sets overflow `exc[3]` and `exc[0]`. Under nearest-even the result is ±∞.
- R9: A quotient below the smallest normal is delivered as a rounded denormal. When that result is inexact and flush mode is off, underflow `exc[2]` is set.
- R10: With `noieee` high, denormal operands act as zeros of their own sign. Quotients below the smallest normal become a zero of the result sign and set only `exc[0]`.
- R11: `exc` bits stay set until reset. `fx` becomes 1 when an operation raises an `exc` bit that was clear.
- R12: `fex` is the OR of the sticky bits ANDed with `xen`, where `xen` bit 4 goes with `vx`, bit 3 with `exc[3]`, bit 2 with `exc[2]`, bit 1 with `exc[1]` and bit 0 with `exc[0]`.
- R13: With `rec` high, `cr` becomes {`fx`, `fex`, `vx`, `exc[3]`} (bit 3 down to 0) at completion. Otherwise `cr` becomes 0.
- R14: ∞ divided by a finite value or zero gives a signed infinity. A finite value divided by ∞, and zero divided by a finite nonzero value, give a signed zero. None of these sets an exception bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a divide (taken when not busy) |
| a | input | 32 | Dividend, binary32 |
| b | input | 32 | Divisor, binary32 |
| rmode | input | 2 | Rounding mode |
| noieee | input | 1 | Flush denormals to signed zero |
| rec | input | 1 | Record request for `cr` |
| xen | input | 5 | Exception enables |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| q | output | 32 | Quotient |
| exc | output | 7 | Sticky causes: [6] sNaN, [5] ∞/∞, [4] 0/0, [3] overflow, [2] underflow, [1] zero-divide, [0] inexact |
| fx | output | 1 | Exception summary |
| fex | output | 1 | Enabled-exception summary |
| vx | output | 1 | Invalid summary |
| fr | output | 1 | Last result rounded up in magnitude |
| fi | output | 1 | Last result inexact |
| cr | output | 4 | Recorded condition nibble |

## Verification
Several properties are checked on every cycle:
- the start/busy/done handshake and that `q` holds between completions;
- that any NaN leaving the block is quiet;
- that `fr` never appears without `fi`;
- that sticky bits never drop;
- that a nonzero `cr` agrees with `fx`, `vx` and the overflow bit.

Only the bench's scenarios can show that quotients and their rounding are right in each mode. The same holds for which special case raises which cause bit, gradual underflow against flush mode, and the enabled summary after enables change. The bench does this with a scoreboard that tracks the sticky state from the expected per-operation causes.

// File: rtl/fp32_div_status.sv
`timescale 1ns/1ps
module fp32_div_status #(
  parameter int EW = 8,
  parameter int FW = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [EW+FW:0]   a,
  input  logic [EW+FW:0]   b,
  input  logic [1:0]       rmode,
  input  logic             noieee,
  input  logic             rec,
  input  logic [4:0]       xen,
  output logic             busy,
  output logic             done,
  output logic [EW+FW:0]   q,
  output logic [6:0]       exc,
  output logic             fx,
  output logic             fex,
  output logic             vx,
  output logic             fr,
  output logic             fi,
  output logic [3:0]       cr
);
  localparam int W   = EW + FW + 1;
  localparam int MW  = FW + 1;
  localparam int QW  = MW + 1;
  localparam int FLW = MW + 2;
  localparam int RW  = MW + 2;
  localparam int XW  = EW + 2;
  localparam int CW  = $clog2(QW);
  localparam int SHW = $clog2(FLW + 1);
  localparam logic [EW-1:0] EMAX = '1;
  localparam logic signed [XW-1:0] EMAX_X = XW'((1 << EW) - 1);
  localparam logic signed [XW-1:0] BIAS_X = XW'((1 << (EW - 1)) - 1);
  localparam logic signed [XW-1:0] ONE_X  = XW'(1);
  localparam logic signed [XW-1:0] FLW_X  = XW'(FLW);
  localparam logic [W-2:0] INF_M  = {EMAX, {FW{1'b0}}};
  localparam logic [W-2:0] MAXF_M = {EMAX - EW'(1), {FW{1'b1}}};
  localparam logic [W-1:0] QNAN   = {1'b0, EMAX, 1'b1, {(FW-1){1'b0}}};

  typedef enum logic [1:0] {S_IDLE, S_NORM, S_DIV, S_FIN} state_t;
  state_t state;

  logic [W-1:0]          a_r, b_r;
  logic [1:0]            rm_r;
  logic                  ni_r, rec_r;
  logic [4:0]            en_r;
  logic [MW-1:0]         ma, mb;
  logic signed [XW-1:0]  ea, eb, eq;
  logic [RW-1:0]         rem;
  logic [QW-1:0]         qm;
  logic [CW-1:0]         cnt;

  assign busy = (state != S_IDLE);

  // operand classes
  wire [EW-1:0] a_e = a_r[W-2:FW];
  wire [EW-1:0] b_e = b_r[W-2:FW];
  wire a_nan  = (a_e == EMAX) && (a_r[FW-1:0] != '0);
  wire b_nan  = (b_e == EMAX) && (b_r[FW-1:0] != '0);
  wire a_inf  = (a_e == EMAX) && (a_r[FW-1:0] == '0);
  wire b_inf  = (b_e == EMAX) && (b_r[FW-1:0] == '0);
  wire a_zero = (a_e == '0) && ((a_r[FW-1:0] == '0) || ni_r);
  wire b_zero = (b_e == '0) && ((b_r[FW-1:0] == '0) || ni_r);
  wire special = a_nan | b_nan | a_inf | b_inf | a_zero | b_zero;
  wire sgn = a_r[W-1] ^ b_r[W-1];

  // rounding of the finite quotient
  wire [FLW-1:0]         full = {qm, |rem};
  wire                   tiny = (eq < ONE_X);
  wire signed [XW-1:0]   shs  = ONE_X - eq;
  wire [SHW-1:0]         sh   = !tiny ? '0 : ((shs > FLW_X) ? SHW'(FLW) : SHW'(shs));
  wire [FLW-1:0]         shifted = full >> sh;
  wire                   lost = |(full << (FLW - int'(sh)));
  wire [MW-1:0]          mant = shifted[FLW-1:2];
  wire                   g    = shifted[1];
  wire                   sbit = shifted[0] | lost;
  wire                   inexact = g | sbit;
  logic                  inc;
  always_comb begin
    unique case (rm_r)
      2'b00:   inc = g & (sbit | mant[0]);
      2'b01:   inc = 1'b0;
      2'b10:   inc = ~sgn & inexact;
      default: inc = sgn & inexact;
    endcase
  end
  wire [EW-1:0]    e_base = tiny ? '0 : (eq[EW-1:0] - EW'(1));
  wire [W-2:0]     sum = {e_base, {FW{1'b0}}} + {{(EW-1){1'b0}}, mant} + {{(W-2){1'b0}}, inc};
  wire             ovf = (eq >= EMAX_X) || (sum[W-2:FW] == EMAX);
  wire             use_inf = (rm_r == 2'b00) || (rm_r == 2'b10 && !sgn) || (rm_r == 2'b11 && sgn);

  logic [W-1:0] r_q;
  logic [6:0]   r_ex;
  logic         r_fr, r_fi;
  always_comb begin
    r_q = '0; r_ex = '0; r_fr = 1'b0; r_fi = 1'b0;
    if (a_nan || b_nan) begin
      r_q = a_nan ? a_r : b_r;
      r_q[FW-1] = 1'b1;
      r_ex[6] = (a_nan && !a_r[FW-1]) || (b_nan && !b_r[FW-1]);
    end else if (a_inf && b_inf) begin
      r_q = QNAN; r_ex[5] = 1'b1;
    end else if (a_zero && b_zero) begin
      r_q = QNAN; r_ex[4] = 1'b1;
    end else if (a_inf) begin
      r_q = {sgn, INF_M};
    end else if (b_zero) begin
      r_q = {sgn, INF_M}; r_ex[1] = 1'b1;
    end else if (b_inf || a_zero) begin
      r_q = {sgn, {(W-1){1'b0}}};
    end else if (ovf) begin
      r_q = {sgn, use_inf ? INF_M : MAXF_M};
      r_ex[3] = 1'b1; r_ex[0] = 1'b1; r_fr = use_inf; r_fi = 1'b1;
    end else if (tiny && ni_r) begin
      r_q = {sgn, {(W-1){1'b0}}};
      r_ex[0] = 1'b1; r_fi = 1'b1;
    end else begin
      r_q = {sgn, sum};
      r_ex[0] = inexact; r_ex[2] = tiny & inexact; r_fr = inc; r_fi = inexact;
    end
  end

  wire [6:0] exc_n = exc | r_ex;
  wire       fx_n  = fx | (|(r_ex & ~exc));
  wire       vx_n  = |exc_n[6:4];
  wire       fex_n = |({vx_n, exc_n[3:0]} & en_r);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; done <= 1'b0; q <= '0; exc <= '0;
      fx <= 1'b0; fex <= 1'b0; vx <= 1'b0; fr <= 1'b0; fi <= 1'b0; cr <= '0;
      a_r <= '0; b_r <= '0; rm_r <= '0; ni_r <= 1'b0; rec_r <= 1'b0; en_r <= '0;
      ma <= '0; mb <= '0; ea <= '0; eb <= '0; eq <= '0; rem <= '0; qm <= '0; cnt <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          a_r <= a; b_r <= b; rm_r <= rmode; ni_r <= noieee; rec_r <= rec; en_r <= xen;
          ma <= {|a[W-2:FW], a[FW-1:0]};
          mb <= {|b[W-2:FW], b[FW-1:0]};
          ea <= (a[W-2:FW] == '0) ? ONE_X : {{(XW-EW){1'b0}}, a[W-2:FW]};
          eb <= (b[W-2:FW] == '0) ? ONE_X : {{(XW-EW){1'b0}}, b[W-2:FW]};
          state <= S_NORM;
        end
        S_NORM: begin
          if (special) begin
            state <= S_FIN;
          end else if (!ma[MW-1] || !mb[MW-1]) begin
            if (!ma[MW-1]) begin ma <= ma << 1; ea <= ea - ONE_X; end
            if (!mb[MW-1]) begin mb <= mb << 1; eb <= eb - ONE_X; end
          end else begin
            if (ma < mb) begin
              rem <= {1'b0, ma, 1'b0};
              eq  <= ea - eb + BIAS_X - ONE_X;
            end else begin
              rem <= {2'b00, ma};
              eq  <= ea - eb + BIAS_X;
            end
            qm <= '0; cnt <= '0; state <= S_DIV;
          end
        end
        S_DIV: begin
          if (rem >= {2'b00, mb}) begin
            rem <= (rem - {2'b00, mb}) << 1;
            qm  <= {qm[QW-2:0], 1'b1};
          end else begin
            rem <= rem << 1;
            qm  <= {qm[QW-2:0], 1'b0};
          end
          cnt <= cnt + CW'(1);
          if (cnt == CW'(QW - 1)) state <= S_FIN;
        end
        default: begin
          q <= r_q; exc <= exc_n; fx <= fx_n; vx <= vx_n; fex <= fex_n;
          fr <= r_fr; fi <= r_fi;
          cr <= rec_r ? {fx_n, fex_n, vx_n, exc_n[3]} : 4'b0000;
          done <= 1'b1;
          state <= S_IDLE;
        end
      endcase
    end
  end

  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy);
  p_q_hold_r1: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(q));
  p_nan_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && q[W-2:FW] == EMAX && q[FW-1:0] != '0) |-> q[FW-1]);
  p_fr_needs_fi_r7: assert property (@(posedge clk) disable iff (!rst_n) fr |-> fi);
  p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (exc != '0) |=> ((exc & $past(exc)) == $past(exc)));
  p_cr_mirror_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (cr != '0) |-> (cr[3] == fx && cr[1] == vx && cr[0] == exc[3]));
endmodule

// File: tb/tb_fp32_div_status.sv
`timescale 1ns/1ps
module tb_fp32_div_status;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, start, noieee, rec;
  logic [31:0] a, b;
  logic [1:0] rmode;
  logic [4:0] xen;
  logic busy, done, fx, fex, vx, fr, fi;
  logic [31:0] q;
  logic [6:0] exc;
  logic [3:0] cr;

  fp32_div_status dut (
    .clk(clk), .rst_n(rst_n), .start(start), .a(a), .b(b), .rmode(rmode),
    .noieee(noieee), .rec(rec), .xen(xen), .busy(busy), .done(done), .q(q),
    .exc(exc), .fx(fx), .fex(fex), .vx(vx), .fr(fr), .fi(fi), .cr(cr));

  int tests = 0;
  int fails = 0;

  logic [31:0] sq_q[$];
  logic [6:0]  sq_ex[$];
  logic        sq_fr[$];
  logic        sq_fi[$];
  logic        sq_rec[$];
  logic [4:0]  sq_en[$];
  string       sq_tag[$];

  logic [6:0] m_exc = '0;
  logic       m_fx  = 1'b0;

  task automatic run(input logic [31:0] ta, input logic [31:0] tb2, input logic [1:0] trm,
                     input logic tni, input logic trec, input logic [4:0] ten,
                     input logic [31:0] xq, input logic [6:0] xex, input logic xfr,
                     input logic xfi, input string tag, input logic glitch);
    while (busy) @(negedge clk);
    a = ta; b = tb2; rmode = trm; noieee = tni; rec = trec; xen = ten; start = 1'b1;
    sq_q.push_back(xq); sq_ex.push_back(xex); sq_fr.push_back(xfr); sq_fi.push_back(xfi);
    sq_rec.push_back(trec); sq_en.push_back(ten); sq_tag.push_back(tag);
    @(negedge clk);
    start = 1'b0;
    if (glitch) begin
      a = 32'h3F800000; b = 32'h3F800000; rmode = 2'b00; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
  endtask

  always @(negedge clk) begin : monitor
    logic [31:0] eq_q; logic [6:0] ex, nexc; logic efr, efi, erec, nfx, nvx, nfex;
    logic [4:0] een; logic [3:0] ncr; string tg;
    if (rst_n && done) begin
      tests++;
      if (sq_q.size() == 0) begin
        fails++;
        $display("FAIL R1: done with no pending operation, q=%h expected none", q);
      end else begin
        eq_q = sq_q.pop_front(); ex = sq_ex.pop_front(); efr = sq_fr.pop_front();
        efi = sq_fi.pop_front(); erec = sq_rec.pop_front(); een = sq_en.pop_front();
        tg = sq_tag.pop_front();
        nexc = m_exc | ex;
        nfx  = m_fx | (|(ex & ~m_exc));
        nvx  = |nexc[6:4];
        nfex = |({nvx, nexc[3:0]} & een);
        ncr  = erec ? {nfx, nfex, nvx, nexc[3]} : 4'b0000;
        m_exc = nexc; m_fx = nfx;
        if (q !== eq_q || exc !== nexc || fx !== nfx || vx !== nvx || fex !== nfex ||
            fr !== efr || fi !== efi || cr !== ncr) begin
          fails++;
          $display("FAIL %s: q=%h exc=%b fx=%b fex=%b vx=%b fr=%b fi=%b cr=%b | expected q=%h exc=%b fx=%b fex=%b vx=%b fr=%b fi=%b cr=%b",
                   tg, q, exc, fx, fex, vx, fr, fi, cr, eq_q, nexc, nfx, nfex, nvx, efr, efi, ncr);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (30000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected complete");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; a = '0; b = '0; rmode = '0; noieee = 1'b0; rec = 1'b0; xen = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tests++;
    if (busy !== 1'b0 || done !== 1'b0 || q !== '0 || exc !== '0 || fx !== 1'b0 || cr !== '0) begin
      fails++;
      $display("FAIL R1 reset: busy=%b done=%b q=%h exc=%b fx=%b cr=%b expected all zero",
               busy, done, q, exc, fx, cr);
    end
    // R6 exact quotient, fx stays 0 (R11)
    run(32'h40C00000, 32'h40000000, 2'b00, 0, 0, 5'h00, 32'h40400000, 7'h00, 0, 0, "R6 R11 exact", 0);
    // R6 R7 rounding of 1/3 in each mode; second start while busy ignored (R1)
    run(32'h3F800000, 32'h40400000, 2'b00, 0, 0, 5'h00, 32'h3EAAAAAB, 7'h01, 1, 1, "R1 R6 R7 nearest", 1);
    run(32'h3F800000, 32'h40400000, 2'b01, 0, 0, 5'h00, 32'h3EAAAAAA, 7'h01, 0, 1, "R6 R7 toward zero", 0);
    run(32'h3F800000, 32'h40400000, 2'b10, 0, 0, 5'h00, 32'h3EAAAAAB, 7'h01, 1, 1, "R6 R7 toward +inf", 0);
    run(32'hBF800000, 32'h40400000, 2'b11, 0, 0, 5'h00, 32'hBEAAAAAB, 7'h01, 1, 1, "R6 R7 negative toward -inf", 0);
    run(32'hBF800000, 32'h40400000, 2'b10, 0, 0, 5'h00, 32'hBEAAAAAA, 7'h01, 0, 1, "R6 R7 negative toward +inf", 0);
    // R2 divide by -0 with record (R13)
    run(32'h3F800000, 32'h80000000, 2'b00, 0, 1, 5'h00, 32'hFF800000, 7'h02, 0, 0, "R2 R13 zero divide", 0);
    run(32'h00000000, 32'h00000000, 2'b00, 0, 0, 5'h00, 32'h7FC00000, 7'h10, 0, 0, "R3 zero over zero", 0);
    run(32'h7F800000, 32'hFF800000, 2'b00, 0, 0, 5'h00, 32'h7FC00000, 7'h20, 0, 0, "R4 inf over inf", 0);
    run(32'h7FC12345, 32'h3F800000, 2'b00, 0, 0, 5'h00, 32'h7FC12345, 7'h00, 0, 0, "R5 R11 quiet NaN passes", 0);
    run(32'h40000000, 32'h7F800001, 2'b00, 0, 0, 5'h00, 32'h7FC00001, 7'h40, 0, 0, "R5 signalling NaN", 0);
    // R8 overflow, recorded
    run(32'h7F7FFFFF, 32'h3F000000, 2'b00, 0, 1, 5'h00, 32'h7F800000, 7'h09, 1, 1, "R8 R13 overflow nearest", 0);
    run(32'h7F7FFFFF, 32'h3F000000, 2'b01, 0, 0, 5'h00, 32'h7F7FFFFF, 7'h09, 0, 1, "R8 overflow toward zero", 0);
    // R9 denormal results
    run(32'h00800000, 32'h40000000, 2'b00, 0, 0, 5'h00, 32'h00400000, 7'h00, 0, 0, "R9 exact denormal", 0);
    run(32'h00800000, 32'h40400000, 2'b00, 0, 0, 5'h00, 32'h002AAAAB, 7'h05, 1, 1, "R9 inexact denormal", 0);
    run(32'h00000001, 32'h3F800000, 2'b00, 0, 0, 5'h00, 32'h00000001, 7'h00, 0, 0, "R9 denormal operand", 0);
    // R10 flush mode
    run(32'h00800000, 32'h40400000, 2'b00, 1, 0, 5'h00, 32'h00000000, 7'h01, 0, 1, "R10 tiny result flushed", 0);
    run(32'h80000001, 32'h3F800000, 2'b00, 1, 0, 5'h00, 32'h80000000, 7'h00, 0, 0, "R10 denormal operand as zero", 0);
    run(32'h00000001, 32'h00000000, 2'b00, 1, 0, 5'h00, 32'h7FC00000, 7'h10, 0, 0, "R10 flushed zero over zero", 0);
    // R14 remaining specials
    run(32'h7F800000, 32'h40000000, 2'b00, 0, 0, 5'h00, 32'h7F800000, 7'h00, 0, 0, "R14 inf over finite", 0);
    run(32'h40000000, 32'hFF800000, 2'b00, 0, 0, 5'h00, 32'h80000000, 7'h00, 0, 0, "R14 finite over -inf", 0);
    run(32'h80000000, 32'h40A00000, 2'b00, 0, 0, 5'h00, 32'h80000000, 7'h00, 0, 0, "R14 -0 over finite", 0);
    // R12 enabled summary with zero-divide enable, recorded
    run(32'h40C00000, 32'h40000000, 2'b00, 0, 1, 5'h02, 32'h40400000, 7'h00, 0, 0, "R12 R13 enabled summary", 0);
    repeat (4) @(negedge clk);
    if (sq_q.size() != 0) begin
      tests++; fails++;
      $display("FAIL R1: %0d results missing, expected 0", sq_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule